// File: doc/BRIEF.md
# Width-Packing Data FIFO Engine

This block runs the data phase of a card transfer. A start pulse loads a byte count and a direction. In receive mode, bytes arrive from the card on a byte-wide valid/ready stream and go into a 32-byte ring. The CPU drains that ring through one port with 1-, 2- or 4-byte reads. In transmit mode, the CPU fills one half of a 64-byte ping-pong buffer with 1-, 2- or 4-byte writes. A half is passed to the card side once it is full, or once software forces out a short half with a flush pulse. The outgoing byte stream then drains that half.

Byte order is fixed for both directions. The earliest byte of the FIFO sits in the most significant byte lane of the access. The engine raises a receive request and a transmit request so that the CPU or a DMA can service the FIFOs. When the count runs out, it drops busy and sets sticky completion flags.

Top module: `pk_engine`

## Requirements
- R1: After reset the outputs are as follows: busy, data_done, prog_done, rx_req, tx_req, card_in_ready and card_out_valid are 0, and cpu_rdata is 0.
- R2: A start pulse has priority over every other input in its cycle.
  - It empties both FIFOs and loads the remaining count from start_count.
  - It takes the direction from start_wr (1 = transmit).
  - It clears both requests and both done flags.
  - busy is 1 in the next cycle.
  - A card handshake that happens in the start cycle is discarded.
- R3: card_in_ready is 1 only when all of these hold: the engine is busy, it is in receive mode, the remaining count is nonzero, and the receive ring holds fewer than 32 bytes. Each accepted byte decrements the count by one.
- R4: rx_req becomes 1 in the cycle after a byte is accepted into the receive ring. A cpu_rd clears it, unless a byte is accepted in the same cycle.
- R5: cpu_size selects the access width N: 0 gives 1 byte, 1 gives 2 bytes, 2 or 3 gives 4 bytes.
  - A cpu_rd pops up to N bytes.
  - The k-th popped byte goes to bits [8(N-1-k)+7 : 8(N-1-k)]. Missing bytes and the unused upper lanes read as 0.
  - cpu_rdata shows the result from the cycle after the read and holds it until the next read.
- R6: A cpu_wr splits cpu_wdata into N bytes, most significant lane first, and appends them to the current fill half. It stops when the half holds 32 bytes. If the half is already marked complete, the whole write is dropped.
- R7: The fill half is marked complete when it reaches 32 bytes, or when flush is pulsed while the half holds at least one byte. A flush on an empty half has no effect. A complete half is handed to the card side in the first cycle in which the drain side is empty, and writing continues in the other half.
- R8: card_out_valid is 1 while all of these hold: the engine is busy, it is in transmit mode, the count is nonzero, and the drain half still holds bytes.
  - card_out_data gives the bytes in the order they were written.
  - card_out_data stays stable while card_out_ready is 0.
  - Each accepted byte decrements the count.
- R9: tx_req is 1 in the cycle after a cycle that meets all of these conditions: the engine stays busy in transmit mode, the count is still nonzero, the fill half is not complete, and there is no cpu_wr.
- R10: In the cycle after the engine is busy with a count of zero:
  - busy drops and data_done becomes 1.
  - prog_done becomes 1 as well for a transmit.
  - Both flags stay set until the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new data phase |
| start_wr | input | 1 | Direction for the new phase: 1 = transmit, 0 = receive |
| start_count | input | CNT_W | Bytes to move in the new phase |
| cpu_rd | input | 1 | CPU read of the receive port |
| cpu_wr | input | 1 | CPU write of the transmit port |
| cpu_size | input | 2 | Access width code (0: 1 byte, 1: 2 bytes, else 4 bytes) |
| cpu_wdata | input | 8*LANES | CPU write data |
| flush | input | 1 | Force the partly filled transmit half out |
| cpu_rdata | output | 8*LANES | Packed read data, registered |
| rx_req | output | 1 | Receive service request |
| tx_req | output | 1 | Transmit service request |
| card_in_valid | input | 1 | Card byte available |
| card_in_data | input | 8 | Card byte |
| card_in_ready | output | 1 | Engine accepts a card byte |
| card_out_valid | output | 1 | Engine offers a byte to the card |
| card_out_data | output | 8 | Byte to the card |
| card_out_ready | input | 1 | Card accepts the byte |
| busy | output | 1 | Data phase in progress |
| data_done | output | 1 | Data phase finished |
| prog_done | output | 1 | Transmit phase finished |

## Verification
The first thing a bad pointer or level in the receive ring shows is a wrong byte or a misplaced lane on cpu_rdata, in the cycle after the read that touched it. Miscounting the ring also shows up as card_in_ready staying low or going high at the wrong fill level. A fault in the ping-pong hand-over shows up in two ways: card_out_data breaks the written order, and tx_req rises or stays low against the fill state, usually within a cycle or two of the flush or the 32nd byte. A wrong remaining count appears only at the end of the phase, as busy falling early or late and data_done following it.

// File: rtl/pk_pkg.sv
package pk_pkg;
  // decode of the access width code into a byte count
  function automatic logic [2:0] size_to_n(input logic [1:0] sz);
    case (sz)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/pk_rx_ring.sv
module pk_rx_ring #(
  parameter int DEPTH = 32,
  parameter int LANES = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clr,
  input  logic                  push,
  input  logic [7:0]            push_data,
  input  logic                  pop,
  input  logic [2:0]            pop_n,
  output logic [8*LANES-1:0]    pop_data,
  output logic [$clog2(DEPTH):0] level
);
  localparam int AW = $clog2(DEPTH);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [AW:0]   lvl, n_ext, take;

  always_comb begin
    n_ext = (AW+1)'(pop_n);
    take  = '0;
    if (pop) take = (n_ext > lvl) ? lvl : n_ext;
  end

  // earliest byte lands in the highest used lane
  always_comb begin
    pop_data = '0;
    for (int k = 0; k < LANES; k++) begin
      if ((AW+1)'(k) < take)
        pop_data[(int'(pop_n) - 1 - k)*8 +: 8] = mem[rd_ptr + AW'(k)];
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      lvl    <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + AW'(1);
      rd_ptr <= rd_ptr + take[AW-1:0];
      lvl    <= lvl + (AW+1)'(push) - take;
    end
  end

  assign level = lvl;
endmodule

// File: rtl/pk_tx_pingpong.sv
module pk_tx_pingpong #(
  parameter int HALF  = 32,
  parameter int LANES = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               wr,
  input  logic [2:0]         wr_n,
  input  logic [8*LANES-1:0] wr_data,
  input  logic               flush,
  input  logic               pop,
  output logic [7:0]         out_data,
  output logic               drain_avail,
  output logic               complete_nxt
);
  localparam int AW = $clog2(HALF);

  logic [7:0]    mem [2*HALF];
  logic          fill_sel, complete;
  logic [AW:0]   fill_cnt, drain_len, room, n_ext, take, fill_next;
  logic [AW-1:0] drain_idx;
  logic          handover;

  always_comb begin
    handover  = complete && (drain_len == '0);
    room      = (AW+1)'(HALF) - fill_cnt;
    n_ext     = (AW+1)'(wr_n);
    take      = '0;
    if (wr && !complete) take = (n_ext > room) ? room : n_ext;
    fill_next = fill_cnt + take;
    if (handover)      complete_nxt = 1'b0;
    else if (complete) complete_nxt = 1'b1;
    else complete_nxt = (fill_next == (AW+1)'(HALF)) || (flush && fill_next != '0);
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < LANES; k++) begin
      if ((AW+1)'(k) < take)
        mem[{fill_sel, fill_cnt[AW-1:0] + AW'(k)}] <= wr_data[(int'(wr_n) - 1 - k)*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      fill_sel  <= 1'b0;
      fill_cnt  <= '0;
      complete  <= 1'b0;
      drain_len <= '0;
      drain_idx <= '0;
    end else if (handover) begin
      fill_sel  <= ~fill_sel;
      drain_len <= fill_cnt;
      drain_idx <= '0;
      fill_cnt  <= '0;
      complete  <= 1'b0;
    end else begin
      if (pop) begin
        drain_idx <= drain_idx + AW'(1);
        drain_len <= drain_len - (AW+1)'(1);
      end
      fill_cnt <= fill_next;
      complete <= complete_nxt;
    end
  end

  assign out_data    = mem[{~fill_sel, drain_idx}];
  assign drain_avail = (drain_len != '0);
endmodule

// File: rtl/pk_count_ctrl.sv
module pk_count_ctrl #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             start_wr,
  input  logic [CNT_W-1:0] start_count,
  input  logic             dec,
  output logic             busy,
  output logic             wr_mode,
  output logic [CNT_W-1:0] remaining,
  output logic             data_done,
  output logic             prog_done
);
  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      wr_mode   <= 1'b0;
      remaining <= '0;
      data_done <= 1'b0;
      prog_done <= 1'b0;
    end else if (start) begin
      busy      <= 1'b1;
      wr_mode   <= start_wr;
      remaining <= start_count;
      data_done <= 1'b0;
      prog_done <= 1'b0;
    end else if (busy && remaining == '0) begin
      busy      <= 1'b0;
      data_done <= 1'b1;
      prog_done <= wr_mode;
    end else if (dec) begin
      remaining <= remaining - CNT_W'(1);
    end
  end
endmodule

// File: rtl/pk_engine.sv
module pk_engine #(
  parameter int CNT_W = 16,
  parameter int DEPTH = 32,
  parameter int LANES = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               start_wr,
  input  logic [CNT_W-1:0]   start_count,
  input  logic               cpu_rd,
  input  logic               cpu_wr,
  input  logic [1:0]         cpu_size,
  input  logic [8*LANES-1:0] cpu_wdata,
  input  logic               flush,
  output logic [8*LANES-1:0] cpu_rdata,
  output logic               rx_req,
  output logic               tx_req,
  input  logic               card_in_valid,
  input  logic [7:0]         card_in_data,
  output logic               card_in_ready,
  output logic               card_out_valid,
  output logic [7:0]         card_out_data,
  input  logic               card_out_ready,
  output logic               busy,
  output logic               data_done,
  output logic               prog_done
);
  import pk_pkg::*;
  localparam int LW = $clog2(DEPTH) + 1;

  logic [2:0]         acc_n;
  logic [LW-1:0]      rx_level;
  logic [8*LANES-1:0] rx_word;
  logic               wr_mode, drain_avail, complete_nxt;
  logic               push, pop, cnt_live;
  logic [CNT_W-1:0]   remaining;

  assign acc_n          = size_to_n(cpu_size);
  assign cnt_live       = busy && (remaining != '0);
  assign card_in_ready  = cnt_live && !wr_mode && (rx_level < LW'(DEPTH));
  assign card_out_valid = cnt_live && wr_mode && drain_avail;
  assign push           = card_in_ready && card_in_valid;
  assign pop            = card_out_valid && card_out_ready;

  pk_count_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .start_wr(start_wr),
    .start_count(start_count), .dec(push || pop), .busy(busy),
    .wr_mode(wr_mode), .remaining(remaining), .data_done(data_done),
    .prog_done(prog_done)
  );

  pk_rx_ring #(.DEPTH(DEPTH), .LANES(LANES)) u_rx (
    .clk(clk), .rst(rst), .clr(start), .push(push), .push_data(card_in_data),
    .pop(cpu_rd), .pop_n(acc_n), .pop_data(rx_word), .level(rx_level)
  );

  pk_tx_pingpong #(.HALF(DEPTH), .LANES(LANES)) u_tx (
    .clk(clk), .rst(rst), .clr(start), .wr(cpu_wr), .wr_n(acc_n),
    .wr_data(cpu_wdata), .flush(flush), .pop(pop), .out_data(card_out_data),
    .drain_avail(drain_avail), .complete_nxt(complete_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_rdata <= '0;
      rx_req    <= 1'b0;
      tx_req    <= 1'b0;
    end else if (start) begin
      rx_req <= 1'b0;
      tx_req <= 1'b0;
    end else begin
      if (cpu_rd) cpu_rdata <= rx_word;
      if (push)        rx_req <= 1'b1;
      else if (cpu_rd) rx_req <= 1'b0;
      tx_req <= !cpu_wr && cnt_live && wr_mode &&
                !(pop && remaining == CNT_W'(1)) && !complete_nxt;
    end
  end
endmodule

// File: rtl/pk_engine_chk.sv
module pk_engine_chk (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       busy,
  input logic       data_done,
  input logic       prog_done,
  input logic       card_in_ready,
  input logic       card_out_valid,
  input logic       card_out_ready,
  input logic [7:0] card_out_data
);
  // R3
  no_dual_dir_chk: assert property (@(posedge clk) disable iff (rst)
    !(card_in_ready && card_out_valid));
  // R10
  prog_implies_data_chk: assert property (@(posedge clk) disable iff (rst)
    prog_done |-> data_done);
  // R10
  idle_when_done_chk: assert property (@(posedge clk) disable iff (rst)
    data_done |-> !busy);
  // R10
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    data_done && !start |=> data_done);
  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> busy && !data_done);
  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    card_out_valid && !card_out_ready && !start |=> card_out_valid && $stable(card_out_data));
endmodule

bind pk_engine pk_engine_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .data_done(data_done),
  .prog_done(prog_done), .card_in_ready(card_in_ready),
  .card_out_valid(card_out_valid), .card_out_ready(card_out_ready),
  .card_out_data(card_out_data)
);

// File: tb/sim_pk_engine.sv
module sim_pk_engine;
  localparam int CLK_NS = 10;
  localparam int CNT_W  = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic start = 0, start_wr = 0, cpu_rd = 0, cpu_wr = 0, flush = 0;
  logic [CNT_W-1:0] start_count = '0;
  logic [1:0]  cpu_size = '0;
  logic [31:0] cpu_wdata = '0, cpu_rdata;
  logic rx_req, tx_req, card_in_valid = 0, card_in_ready, card_out_valid, card_out_ready = 0;
  logic [7:0] card_in_data = '0, card_out_data;
  logic busy, data_done, prog_done;

  always #(CLK_NS/2) clk = ~clk;

  pk_engine u0 (
    .clk(clk), .rst(rst), .start(start), .start_wr(start_wr), .start_count(start_count),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_size(cpu_size), .cpu_wdata(cpu_wdata),
    .flush(flush), .cpu_rdata(cpu_rdata), .rx_req(rx_req), .tx_req(tx_req),
    .card_in_valid(card_in_valid), .card_in_data(card_in_data), .card_in_ready(card_in_ready),
    .card_out_valid(card_out_valid), .card_out_data(card_out_data),
    .card_out_ready(card_out_ready), .busy(busy), .data_done(data_done), .prog_done(prog_done)
  );

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%h exp=%h t=%0t", req, got, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [7:0] q_rx[$], q_fill[$], q_drain[$];
  bit m_busy, m_wr, m_dd, m_pd, m_rxr, m_txr, m_comp;
  int m_cnt, push_total;
  logic [31:0] m_rdata;

  always @(posedge clk) begin
    if (rst) begin
      q_rx.delete(); q_fill.delete(); q_drain.delete();
      m_busy = 0; m_wr = 0; m_dd = 0; m_pd = 0; m_rxr = 0; m_txr = 0; m_comp = 0;
      m_cnt = 0; push_total = 0; m_rdata = '0;
    end else begin
      bit in_rdy, out_v, pb, ob, hand;
      int cnt_pre, n;
      logic [31:0] v;
      in_rdy = m_busy && !m_wr && m_cnt != 0 && q_rx.size() < 32;
      out_v  = m_busy && m_wr && m_cnt != 0 && q_drain.size() > 0;
      pb = in_rdy && card_in_valid;
      ob = out_v && card_out_ready;
      if (start) begin
        if (pb) push_total++;
        q_rx.delete(); q_fill.delete(); q_drain.delete();
        m_cnt = int'(start_count); m_wr = start_wr; m_busy = 1;
        m_dd = 0; m_pd = 0; m_comp = 0; m_rxr = 0; m_txr = 0;
      end else begin
        n = (cpu_size == 0) ? 1 : (cpu_size == 1) ? 2 : 4;
        cnt_pre = m_cnt;
        hand = m_comp && q_drain.size() == 0;
        if (cpu_rd) begin
          v = '0;
          for (int k = 0; k < n; k++)
            if (q_rx.size() > 0) v[(n-1-k)*8 +: 8] = q_rx.pop_front();
          m_rdata = v;
        end
        if (pb) begin q_rx.push_back(card_in_data); push_total++; m_cnt--; end
        m_rxr = pb ? 1'b1 : (cpu_rd ? 1'b0 : m_rxr);
        if (ob) begin void'(q_drain.pop_front()); m_cnt--; end
        if (hand) begin
          q_drain = q_fill; q_fill.delete(); m_comp = 0;
        end else if (!m_comp) begin
          if (cpu_wr)
            for (int k = 0; k < n; k++)
              if (q_fill.size() < 32) q_fill.push_back(cpu_wdata[(n-1-k)*8 +: 8]);
          m_comp = (q_fill.size() == 32) || (flush && q_fill.size() > 0);
        end
        if (m_busy && cnt_pre == 0) begin m_busy = 0; m_dd = 1; m_pd = m_wr; end
        m_txr = !cpu_wr && m_busy && m_wr && m_cnt != 0 && !m_comp;
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      bit e_in, e_out;
      e_in  = m_busy && !m_wr && m_cnt != 0 && q_rx.size() < 32;
      e_out = m_busy && m_wr && m_cnt != 0 && q_drain.size() > 0;
      chk(card_in_ready == e_in, "R3 card_in_ready", 32'(card_in_ready), 32'(e_in));
      chk(rx_req == m_rxr, "R4 rx_req", 32'(rx_req), 32'(m_rxr));
      chk(cpu_rdata == m_rdata, "R5 cpu_rdata", cpu_rdata, m_rdata);
      chk(card_out_valid == e_out, "R8 card_out_valid", 32'(card_out_valid), 32'(e_out));
      if (e_out) // byte order also covers R6 and R7
        chk(card_out_data == q_drain[0], "R8 card_out_data", 32'(card_out_data), 32'(q_drain[0]));
      chk(tx_req == m_txr, "R9 tx_req", 32'(tx_req), 32'(m_txr));
      chk(busy == m_busy, "R10 busy", 32'(busy), 32'(m_busy));
      chk(data_done == m_dd, "R10 data_done", 32'(data_done), 32'(m_dd));
      chk(prog_done == m_pd, "R10 prog_done", 32'(prog_done), 32'(m_pd));
    end
  end

  // card-side source and sink with pseudo-random pacing
  logic [15:0] lf = 16'hACE1;
  bit src_on = 1;
  initial forever begin
    @(negedge clk);
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    card_in_valid  = src_on && lf[0];
    card_in_data   = 8'(push_total * 37 + 5);
    card_out_ready = lf[3] | lf[7];
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired got=%0d exp=0", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic do_start(input bit wr, input int cnt);
    start = 1; start_wr = wr; start_count = CNT_W'(cnt);
    @(negedge clk); start = 0;
    // R2: busy, no flags, no requests right after start
    chk(busy && !data_done && !prog_done && !rx_req && !tx_req, "R2 start state",
        {27'd0, busy, data_done, prog_done, rx_req, tx_req}, 32'h10);
  endtask

  task automatic rd(input logic [1:0] sz);
    cpu_rd = 1; cpu_size = sz; @(negedge clk); cpu_rd = 0;
  endtask

  task automatic wr(input logic [1:0] sz, input logic [31:0] d);
    cpu_wr = 1; cpu_size = sz; cpu_wdata = d; @(negedge clk); cpu_wr = 0;
  endtask

  task automatic pulse_flush();
    flush = 1; @(negedge clk); flush = 0;
  endtask

  task automatic wait_txreq();
    while (!tx_req) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    chk({busy, data_done, prog_done, rx_req, tx_req, card_in_ready, card_out_valid} == 7'd0,
        "R1 reset outputs", {25'd0, busy, data_done, prog_done, rx_req, tx_req, card_in_ready, card_out_valid}, 0);
    chk(cpu_rdata == 0, "R1 reset rdata", cpu_rdata, 0);

    // receive 40 bytes, let the ring fill to its limit first
    do_start(0, 40);
    repeat (120) @(negedge clk);
    for (int i = 0; i < 40; i++) begin
      rd(2'(i % 4));
      if (i % 3 == 0) @(negedge clk);
    end
    while (busy) begin rd(2'd2); @(negedge clk); end
    repeat (3) rd(2'd2);
    rd(2'd1);
    rd(2'd0);

    // transmit 70 bytes through both halves
    do_start(1, 70);
    wait_txreq();
    for (int i = 0; i < 8; i++) wr(2'd2, 32'h10203040 + 32'(i) * 32'h01010101);
    wr(2'd2, 32'hDEADBEEF);   // dropped: half complete (R6)
    wait_txreq();
    for (int i = 0; i < 4; i++) wr(2'd3, 32'hA0B0C0D0 + 32'(i));
    wr(2'd1, 32'h00005A6B);
    pulse_flush();            // short half (R7)
    wait_txreq();
    for (int i = 0; i < 5; i++) wr(2'd2, 32'h55660000 + 32'(i));
    pulse_flush();
    while (busy) @(negedge clk);
    pulse_flush();            // empty half: no effect (R7)
    repeat (4) @(negedge clk);

    // zero-length phase
    do_start(1, 0);
    repeat (3) @(negedge clk);

    // abort a receive phase with a new start
    do_start(0, 10);
    repeat (6) @(negedge clk);
    do_start(0, 5);
    while (busy) begin rd(2'd0); @(negedge clk); end
    repeat (6) rd(2'd0);

    // small byte-wise transmit
    do_start(1, 3);
    wait_txreq();
    wr(2'd0, 32'h000000C1);
    wr(2'd0, 32'h000000C2);
    wr(2'd0, 32'h000000C3);
    pulse_flush();
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule